// File: doc/BRIEF.md
# Configuration Unlock Key Detector

This block watches host I/O write cycles and decides when a legacy I/O controller may go into its configuration mode. Entry takes two stages. First, a four-byte selection prefix is written to a fixed, write-only selection port. The last two bytes of that prefix choose one of three base addresses. Second, a 32-byte key must be written, in order, to the chosen base port. Only when the last key byte matches does the block raise its configuration-mode flag and publish the newly chosen base address.

Each expected key byte comes from an 8-bit shift register, not from a stored table. A wrong byte on the expected port at any point sends the detector back to waiting for the start of the prefix. Writes to any other address are ignored. While the block is in configuration mode, a separate exit input (driven by the register decoder when the configure-control register is written) clears the mode. The published base address stays where it is until the next complete unlock, so the register decoders keep using it.

Top module: `cfg_unlock_detect`

## Requirements
- R1: A synchronous active-high reset clears the configuration-mode flag and sets the base address output to 0x03F0.
- R2: Each byte is taken on a rising clock edge while the write strobe is high. The sequence is 0x86, 0x80, 0x55, 0x55 written to port 0x0279, then the 32 key bytes written to 0x03F0. On the clock edge that takes the last key byte, the mode flag goes high and the base reads 0x03F0.
- R3: The third and fourth prefix bytes choose the base: 0x55 then 0xAA selects 0x03BD, and 0xAA then 0x55 selects 0x0370. The key is then expected on that base port.
- R4: Key byte 0 is 0x6A. Each next byte is the previous one shifted right by one bit, with bit 7 set to the XOR of the previous bit 0 and bit 1; byte 31 is therefore 0x39. The mode flag stays low after only 31 correct key bytes.
- R5: A wrong prefix byte on port 0x0279 returns the detector to waiting for 0x86. A correct remainder of the sequence alone then does not unlock it.
- R6: A wrong key byte on the selected base port returns the detector to waiting for 0x86. A selection pair of 0xAA, 0xAA is invalid and does the same.
- R7: During the prefix and the key, writes to any address other than the expected port are ignored. This includes selection-port writes during the key and key bytes sent to a base that was not selected.
- R8: When the exit input is high at a clock edge while in configuration mode, the mode flag is low after that edge, and the base address output keeps its value.
- R9: While in configuration mode, and without exit, all I/O writes leave the mode flag and the base address unchanged. After an exit, a new complete sequence may select a different base.
- R10: The base address output changes only on a complete unlock. A failed attempt leaves the previous base in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| io_wr_i | input | 1 | I/O write strobe, one byte taken per high cycle |
| io_addr_i | input | 16 | I/O write address |
| io_data_i | input | 8 | I/O write data byte |
| cfg_exit_i | input | 1 | Leave configuration mode |
| cfg_mode_o | output | 1 | Configuration mode active |
| cfg_base_o | output | 16 | Selected base (index) port address |

## Verification
The bench targets the off-by-one in the key length. It stops after 31 bytes, where a counter with the wrong limit would unlock one byte early or never unlock at all. It aborts the key midway and then sends the correct remaining bytes, which a detector that stalls on a bad byte instead of restarting would accept. It interleaves foreign-port writes and sends a full key to a base that was not selected; a detector that matched only on data, or on any base, would unlock falsely. Last, it checks that the base survives exit and failed attempts, which catches a design that publishes the candidate base as soon as the prefix completes.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] io_addr_t;
    typedef logic [DATA_W-1:0] io_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PFX1,
        ST_SELA,
        ST_SELB,
        ST_KEY,
        ST_CFG
    } unl_state_e;

    typedef struct packed {
        unl_state_e st;
        io_byte_t   sel_a;
        io_addr_t   cand;
        io_addr_t   base;
        logic       mode;
    } unl_regs_t;

    // one step of the key sequence generator
    function automatic io_byte_t key_step(io_byte_t cur);
        return {cur[0] ^ cur[1], cur[DATA_W-1:1]};
    endfunction

    // key byte at position idx counted from the seed
    function automatic io_byte_t key_byte(io_byte_t seed, int unsigned idx);
        io_byte_t b;
        b = seed;
        for (int unsigned i = 0; i < idx; i++) begin
            b = key_step(b);
        end
        return b;
    endfunction

endpackage

// File: rtl/cfg_unlock_keygen.sv
module cfg_unlock_keygen
    import cfg_unlock_pkg::*;
#(
    parameter int       KEY_LEN  = 32,
    parameter io_byte_t KEY_SEED = 8'h6A
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     load_i,
    input  logic     step_i,
    output io_byte_t expect_o,
    output logic     last_o
);

    localparam int CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(KEY_LEN - 1);

    typedef struct packed {
        io_byte_t         cur;
        logic [CNT_W-1:0] cnt;
    } kg_regs_t;

    kg_regs_t kg_d, kg_q;

    always_comb begin
        kg_d = kg_q;
        if (load_i) begin
            kg_d.cur = KEY_SEED;
            kg_d.cnt = '0;
        end else if (step_i) begin
            kg_d.cur = key_step(kg_q.cur);
            kg_d.cnt = kg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            kg_q.cur <= KEY_SEED;
            kg_q.cnt <= '0;
        end else begin
            kg_q <= kg_d;
        end
    end

    assign expect_o = kg_q.cur;
    assign last_o   = (kg_q.cnt == LAST_IDX);

endmodule

// File: rtl/cfg_unlock_basesel.sv
module cfg_unlock_basesel
    import cfg_unlock_pkg::*;
#(
    parameter io_byte_t SEL_LO = 8'h55,
    parameter io_byte_t SEL_HI = 8'hAA,
    parameter io_addr_t BASE_A = 16'h03F0,
    parameter io_addr_t BASE_B = 16'h03BD,
    parameter io_addr_t BASE_C = 16'h0370
) (
    input  io_byte_t sel_a_i,
    input  io_byte_t sel_b_i,
    output io_addr_t base_o,
    output logic     valid_o
);

    logic a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = (sel_a_i == SEL_LO);
        a_hi = (sel_a_i == SEL_HI);
        b_lo = (sel_b_i == SEL_LO);
        b_hi = (sel_b_i == SEL_HI);
        valid_o = 1'b1;
        base_o  = BASE_A;
        if (a_lo && b_lo) begin
            base_o = BASE_A;
        end else if (a_lo && b_hi) begin
            base_o = BASE_B;
        end else if (a_hi && b_lo) begin
            base_o = BASE_C;
        end else begin
            valid_o = 1'b0;
        end
    end

endmodule

// File: rtl/cfg_unlock_detect.sv
module cfg_unlock_detect
    import cfg_unlock_pkg::*;
#(
    parameter int       KEY_LEN  = 32,
    parameter io_byte_t KEY_SEED = 8'h6A,
    parameter io_addr_t SEL_PORT = 16'h0279,
    parameter io_byte_t PFX_0    = 8'h86,
    parameter io_byte_t PFX_1    = 8'h80,
    parameter io_byte_t SEL_LO   = 8'h55,
    parameter io_byte_t SEL_HI   = 8'hAA,
    parameter io_addr_t BASE_A   = 16'h03F0,
    parameter io_addr_t BASE_B   = 16'h03BD,
    parameter io_addr_t BASE_C   = 16'h0370
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        io_wr_i,
    input  logic [15:0] io_addr_i,
    input  logic [7:0]  io_data_i,
    input  logic        cfg_exit_i,
    output logic        cfg_mode_o,
    output logic [15:0] cfg_base_o
);

    unl_regs_t r_d, r_q;

    logic     kg_load, kg_step, kg_last;
    io_byte_t kg_expect;
    io_addr_t sel_base;
    logic     sel_ok;
    logic     wr_sel, wr_key;

    cfg_unlock_keygen #(
        .KEY_LEN (KEY_LEN),
        .KEY_SEED(KEY_SEED)
    ) i_keygen (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (kg_load),
        .step_i  (kg_step),
        .expect_o(kg_expect),
        .last_o  (kg_last)
    );

    cfg_unlock_basesel #(
        .SEL_LO(SEL_LO),
        .SEL_HI(SEL_HI),
        .BASE_A(BASE_A),
        .BASE_B(BASE_B),
        .BASE_C(BASE_C)
    ) i_basesel (
        .sel_a_i(r_q.sel_a),
        .sel_b_i(io_data_i),
        .base_o (sel_base),
        .valid_o(sel_ok)
    );

    assign wr_sel = io_wr_i && (io_addr_i == SEL_PORT);
    assign wr_key = io_wr_i && (io_addr_i == r_q.cand);

    always_comb begin
        r_d     = r_q;
        kg_load = 1'b0;
        kg_step = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (wr_sel && io_data_i == PFX_0) begin
                    r_d.st = ST_PFX1;
                end
            end
            ST_PFX1: begin
                if (wr_sel) begin
                    r_d.st = (io_data_i == PFX_1) ? ST_SELA : ST_IDLE;
                end
            end
            ST_SELA: begin
                if (wr_sel) begin
                    if (io_data_i == SEL_LO || io_data_i == SEL_HI) begin
                        r_d.sel_a = io_data_i;
                        r_d.st    = ST_SELB;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_SELB: begin
                if (wr_sel) begin
                    if (sel_ok) begin
                        r_d.cand = sel_base;
                        r_d.st   = ST_KEY;
                        kg_load  = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_KEY: begin
                if (wr_key) begin
                    if (io_data_i != kg_expect) begin
                        r_d.st = ST_IDLE;
                    end else if (kg_last) begin
                        r_d.st   = ST_CFG;
                        r_d.mode = 1'b1;
                        r_d.base = r_q.cand;
                    end else begin
                        kg_step = 1'b1;
                    end
                end
            end
            ST_CFG: begin
                if (cfg_exit_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.mode = 1'b0;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.mode = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.st    <= ST_IDLE;
            r_q.sel_a <= '0;
            r_q.cand  <= BASE_A;
            r_q.base  <= BASE_A;
            r_q.mode  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_mode_o = r_q.mode;
    assign cfg_base_o = r_q.base;

endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk
    import cfg_unlock_pkg::*;
#(
    parameter int       KEY_LEN  = 32,
    parameter io_byte_t KEY_SEED = 8'h6A,
    parameter io_addr_t BASE_A   = 16'h03F0,
    parameter io_addr_t BASE_B   = 16'h03BD,
    parameter io_addr_t BASE_C   = 16'h0370
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic        io_wr_i,
    input logic [15:0] io_addr_i,
    input logic [7:0]  io_data_i,
    input logic        cfg_exit_i,
    input logic        cfg_mode_o,
    input logic [15:0] cfg_base_o
);

    localparam io_byte_t LAST_KEY = key_byte(KEY_SEED, KEY_LEN - 1);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (!cfg_mode_o && cfg_base_o == BASE_A));

    // R4
    final_key_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cfg_mode_o) |-> ($past(io_wr_i) && $past(io_data_i) == LAST_KEY));

    // R2
    key_port_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cfg_mode_o) |-> ($past(io_addr_i) == cfg_base_o));

    // R3
    base_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_base_o == BASE_A || cfg_base_o == BASE_B || cfg_base_o == BASE_C));

    // R8
    exit_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_mode_o && cfg_exit_i) |=> (!cfg_mode_o && $stable(cfg_base_o)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_mode_o && !cfg_exit_i) |=> (cfg_mode_o && $stable(cfg_base_o)));

    // R10
    base_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$rose(cfg_mode_o)) |-> $stable(cfg_base_o));

endmodule

bind cfg_unlock_detect cfg_unlock_chk #(
    .KEY_LEN (KEY_LEN),
    .KEY_SEED(KEY_SEED),
    .BASE_A  (BASE_A),
    .BASE_B  (BASE_B),
    .BASE_C  (BASE_C)
) i_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .io_wr_i   (io_wr_i),
    .io_addr_i (io_addr_i),
    .io_data_i (io_data_i),
    .cfg_exit_i(cfg_exit_i),
    .cfg_mode_o(cfg_mode_o),
    .cfg_base_o(cfg_base_o)
);

// File: tb/test_cfg_unlock_detect.sv
module test_cfg_unlock_detect;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr;
    logic [15:0] io_addr;
    logic [7:0]  io_data;
    logic        cfg_exit;
    logic        cfg_mode;
    logic [15:0] cfg_base;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_unlock_detect i_cfg_unlock_detect (
        .clk_i     (clk),
        .rst_i     (rst),
        .io_wr_i   (io_wr),
        .io_addr_i (io_addr),
        .io_data_i (io_data),
        .cfg_exit_i(cfg_exit),
        .cfg_mode_o(cfg_mode),
        .cfg_base_o(cfg_base)
    );

    function automatic logic [7:0] key_at(int n);
        logic [7:0] b;
        b = 8'h6A;
        for (int i = 0; i < n; i++) b = {b[0] ^ b[1], b[7:1]};
        return b;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_wr   = 1'b1;
        io_addr = a;
        io_data = d;
        @(negedge clk);
        io_wr   = 1'b0;
    endtask

    task automatic send_prefix(logic [7:0] s0, logic [7:0] s1);
        io_write(16'h0279, 8'h86);
        io_write(16'h0279, 8'h80);
        io_write(16'h0279, s0);
        io_write(16'h0279, s1);
    endtask

    task automatic send_key(logic [15:0] base, int first, int last);
        for (int i = first; i <= last; i++) io_write(base, key_at(i));
    endtask

    task automatic do_exit();
        @(negedge clk);
        cfg_exit = 1'b1;
        @(negedge clk);
        cfg_exit = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode", {15'd0, cfg_mode}, 16'd0);
        chk("R1 base", cfg_base, 16'h03F0);
    endtask

    task automatic t_unlock_3f0();
        chk("R4 key first", {8'd0, key_at(0)}, 16'h006A);
        chk("R4 key last", {8'd0, key_at(31)}, 16'h0039);
        send_prefix(8'h55, 8'h55);
        send_key(16'h03F0, 0, 30);
        chk("R4 31 bytes", {15'd0, cfg_mode}, 16'd0);
        send_key(16'h03F0, 31, 31);
        chk("R2 mode", {15'd0, cfg_mode}, 16'd1);
        chk("R2 base", cfg_base, 16'h03F0);
        do_exit();
        chk("R8 mode", {15'd0, cfg_mode}, 16'd0);
        chk("R8 base", cfg_base, 16'h03F0);
    endtask

    task automatic t_select_others();
        send_prefix(8'h55, 8'hAA);
        send_key(16'h03BD, 0, 31);
        chk("R3 3BD mode", {15'd0, cfg_mode}, 16'd1);
        chk("R3 3BD base", cfg_base, 16'h03BD);
        do_exit();
        chk("R8 keep 3BD", cfg_base, 16'h03BD);
        send_prefix(8'hAA, 8'h55);
        send_key(16'h0370, 0, 31);
        chk("R3 370 mode", {15'd0, cfg_mode}, 16'd1);
        chk("R3 370 base", cfg_base, 16'h0370);
        do_exit();
    endtask

    task automatic t_bad_key();
        send_prefix(8'h55, 8'h55);
        send_key(16'h03F0, 0, 9);
        io_write(16'h03F0, key_at(10) ^ 8'h01);
        send_key(16'h03F0, 11, 31);
        chk("R6 bad key mode", {15'd0, cfg_mode}, 16'd0);
        chk("R10 base kept", cfg_base, 16'h0370);
        send_prefix(8'hAA, 8'hAA);
        send_key(16'h03F0, 0, 31);
        chk("R6 AA AA mode", {15'd0, cfg_mode}, 16'd0);
        send_prefix(8'h55, 8'h55);
        send_key(16'h03F0, 0, 31);
        chk("R6 restart mode", {15'd0, cfg_mode}, 16'd1);
        chk("R10 new base", cfg_base, 16'h03F0);
        do_exit();
    endtask

    task automatic t_bad_prefix();
        io_write(16'h0279, 8'h86);
        io_write(16'h0279, 8'h81);
        io_write(16'h0279, 8'h55);
        io_write(16'h0279, 8'h55);
        send_key(16'h03F0, 0, 31);
        chk("R5 mode", {15'd0, cfg_mode}, 16'd0);
        io_write(16'h0279, 8'h86);
        io_write(16'h0279, 8'h80);
        io_write(16'h0279, 8'h12);
        io_write(16'h0279, 8'h55);
        send_key(16'h03F0, 0, 31);
        chk("R5 bad sel mode", {15'd0, cfg_mode}, 16'd0);
    endtask

    task automatic t_foreign_writes();
        io_write(16'h0279, 8'h86);
        io_write(16'h0080, 8'h00);
        io_write(16'h0279, 8'h80);
        io_write(16'h03F1, 8'hFF);
        io_write(16'h0279, 8'hAA);
        io_write(16'h0279, 8'h55);
        send_key(16'h03F0, 0, 31);
        chk("R7 other base mode", {15'd0, cfg_mode}, 16'd0);
        for (int i = 0; i < 32; i++) begin
            io_write(16'h0371, 8'h00);
            io_write(16'h0279, 8'h86);
            io_write(16'h0370, key_at(i));
        end
        chk("R7 mode", {15'd0, cfg_mode}, 16'd1);
        chk("R7 base", cfg_base, 16'h0370);
    endtask

    task automatic t_cfg_ignore();
        send_prefix(8'h55, 8'hAA);
        send_key(16'h03BD, 0, 31);
        io_write(16'h0370, 8'h02);
        chk("R9 mode", {15'd0, cfg_mode}, 16'd1);
        chk("R9 base", cfg_base, 16'h0370);
        do_exit();
        chk("R8 exit", {15'd0, cfg_mode}, 16'd0);
        send_prefix(8'h55, 8'hAA);
        send_key(16'h03BD, 0, 31);
        chk("R9 reselect", cfg_base, 16'h03BD);
        do_exit();
    endtask

    initial begin
        rst      = 1'b1;
        io_wr    = 1'b0;
        io_addr  = '0;
        io_data  = '0;
        cfg_exit = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unlock_3f0();
        t_select_others();
        t_bad_key();
        t_bad_prefix();
        t_foreign_writes();
        t_cfg_ignore();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule